// File: doc/BRIEF.md
# 64-bit SECDED Error Correction Unit

This block protects a 64-bit data word with eight check bits, so that a 72-bit codeword can be written to memory and checked when it is read back. It serves a memory path with one write port and one read port, or an external memory that is 72 bits wide. The write side is purely combinational. It turns the data being written into its eight check bits, and the caller stores these next to the data. The read side takes a 72-bit codeword and computes a seven-bit syndrome and an overall parity result. It repairs any single flipped bit and reports words that cannot be repaired. All read-side results are presented one clock after the codeword arrives.

The code is an extended Hamming code. Data bits occupy the Hamming positions that are not powers of two. Seven check bits sit at the power-of-two positions. An eighth bit makes the parity of the whole codeword even. Reads and writes to the same word in the same cycle are outside this unit's concern; the memory around it must keep them apart.

Top module: `secded_unit`

## Requirements
- R1: Data bit i is assigned Hamming position pos(i), where pos(i) is the (i+1)-th integer of 3 or more that is not a power of two (so pos(0)=3 and pos(63)=71). Within the same cycle, `wrCheck[j]` for j in 0..6 equals the XOR of every `wrData[i]` whose pos(i) has bit j set.
- R2: `wrCheck[7]` makes the XOR of all 64 data bits and all 8 check bits zero. For example, data 1 encodes to 8'h83 and data bit 63 alone encodes to 8'hC7.
- R3: The codeword layout on `rdCode` is: bits [63:0] data, bits [70:64] check bits 0..6, and bit 71 the overall parity bit. `rdOutValid` is high in exactly the cycle after each cycle in which `rdValid` is high.
- R4: For a codeword that is correct, `rdDataOut` equals `rdCode[63:0]` and neither error flag is raised.
- R5: When exactly one data bit is flipped, `rdDataOut` returns the original data and `errSingle` is raised.
- R6: When exactly one of bits [71:64] is flipped, `rdDataOut` returns the unchanged data and `errSingle` is raised.
- R7: When exactly two bits of the codeword are flipped, `errDouble` is raised, `errSingle` stays low, and `rdDataOut` carries `rdCode[63:0]` without correction.
- R8: When the overall parity is odd but the syndrome exceeds 71 (for example, all seven bits [70:64] are flipped), the word is treated as uncorrectable. `errDouble` is raised and the data passes through uncorrected.
- R9: `errSingle` and `errDouble` are never high together, and both are low whenever `rdOutValid` is low.
- R10: In a cycle after one with `rdValid` low, `rdDataOut` keeps its previous value.
- R11: While `rstN` is low, `rdOutValid`, both flags and `rdDataOut` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrData | input | 64 | Data to be encoded for writing |
| wrCheck | output | 8 | Check bits for wrData, combinational |
| rdValid | input | 1 | rdCode holds a codeword to decode |
| rdCode | input | 72 | Codeword read from memory |
| rdOutValid | output | 1 | Registered result is valid |
| rdDataOut | output | 64 | Corrected or passed-through data |
| errSingle | output | 1 | A single-bit error was found (and corrected) |
| errDouble | output | 1 | An uncorrectable error was found |

## Verification
The decoder is driven with six kinds of input: clean codewords, a single flip in a random data bit, a single flip in one of the eight check bits, two flips at random distinct positions, seven flips that push the syndrome past the last valid position, and idle cycles. A clean word shows that nothing is altered when nothing is wrong. A data flip shows that the syndrome points to the right bit. A check-bit flip, including a flip of the parity bit, shows that correction never touches the data when the fault lies outside it. Double flips and out-of-range syndromes show that the unit refuses to correct a word it cannot trust, and idle cycles show that the output holds and the flags stay quiet. The encoder is checked against two hand-computed vectors and against every random word.

// File: rtl/secded_pkg.sv
package secded_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;      // capture a new read result
    logic applyFix;  // flip the bit the syndrome points to
  } dpStrobe_t;

  // Hamming position of data bit idx: the idx-th non power of two from 3 up
  function automatic int dataPos(input int idx);
    int cnt;
    int res;
    cnt = 0;
    res = 0;
    for (int p = 3; p < 4096; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == idx && res == 0) res = p;
        cnt++;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/secded_datapath.sv
module secded_datapath
  import secded_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int HC_W   = 7
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [DATA_W-1:0]       wrData,
  output logic [HC_W:0]           wrCheck,
  input  logic [DATA_W+HC_W:0]    rdCode,
  input  dpStrobe_t               strobe,
  output logic                    synNonZero,
  output logic                    parityErr,
  output logic                    synInRange,
  output logic [DATA_W-1:0]       rdDataOut
);
  localparam int CODE_W   = DATA_W + HC_W + 1;
  localparam int LAST_POS = CODE_W - 1;

  logic [HC_W-1:0]   posTab [DATA_W];
  logic [HC_W-1:0]   encHc;
  logic [HC_W-1:0]   syn;
  logic [DATA_W-1:0] fixMask;
  logic [DATA_W-1:0] corrected;
  logic [DATA_W-1:0] dataQ;

  // position table computed at elaboration
  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_pos
    localparam int P = dataPos(gi);
    assign posTab[gi] = HC_W'(P);
  end

  // write side encoder
  always_comb begin
    encHc = '0;
    for (int i = 0; i < DATA_W; i++) begin
      for (int j = 0; j < HC_W; j++) begin
        if (posTab[i][j]) encHc[j] = encHc[j] ^ wrData[i];
      end
    end
  end
  assign wrCheck = {^{encHc, wrData}, encHc};

  // read side syndrome
  always_comb begin
    syn = rdCode[DATA_W +: HC_W];
    for (int i = 0; i < DATA_W; i++) begin
      for (int j = 0; j < HC_W; j++) begin
        if (posTab[i][j]) syn[j] = syn[j] ^ rdCode[i];
      end
    end
  end

  assign parityErr  = ^rdCode;
  assign synNonZero = |syn;
  assign synInRange = ({{(32-HC_W){1'b0}}, syn} <= 32'(LAST_POS));

  always_comb begin
    for (int i = 0; i < DATA_W; i++) fixMask[i] = (syn == posTab[i]);
  end

  assign corrected = rdCode[DATA_W-1:0] ^ (strobe.applyFix ? fixMask : '0);

  always_ff @(posedge clk) begin
    if (!rstN)            dataQ <= '0;
    else if (strobe.load) dataQ <= corrected;
  end

  assign rdDataOut = dataQ;

endmodule

// File: rtl/secded_control.sv
module secded_control
  import secded_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      rdValid,
  input  logic      synNonZero,
  input  logic      parityErr,
  input  logic      synInRange,
  output dpStrobe_t strobe,
  output logic      rdOutValid,
  output logic      errSingle,
  output logic      errDouble
);
  logic isSingle;
  logic isDouble;
  logic validQ, singleQ, doubleQ;

  // odd parity: one flip, unless the syndrome names no real position
  assign isSingle = parityErr && (!synNonZero || synInRange);
  // even parity with a nonzero syndrome, or an impossible syndrome
  assign isDouble = (synNonZero && !parityErr) ||
                    (parityErr && synNonZero && !synInRange);

  always_comb begin
    strobe.load     = rdValid;
    strobe.applyFix = rdValid && parityErr && synNonZero && synInRange;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ  <= 1'b0;
      singleQ <= 1'b0;
      doubleQ <= 1'b0;
    end else begin
      validQ  <= rdValid;
      singleQ <= rdValid && isSingle;
      doubleQ <= rdValid && isDouble;
    end
  end

  assign rdOutValid = validQ;
  assign errSingle  = singleQ;
  assign errDouble  = doubleQ;

endmodule

// File: rtl/secded_unit.sv
module secded_unit
  import secded_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int HC_W   = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [DATA_W-1:0]    wrData,
  output logic [HC_W:0]        wrCheck,
  input  logic                 rdValid,
  input  logic [DATA_W+HC_W:0] rdCode,
  output logic                 rdOutValid,
  output logic [DATA_W-1:0]    rdDataOut,
  output logic                 errSingle,
  output logic                 errDouble
);
  dpStrobe_t strobe;
  logic synNonZero, parityErr, synInRange;

  secded_datapath #(.DATA_W(DATA_W), .HC_W(HC_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .wrData     (wrData),
    .wrCheck    (wrCheck),
    .rdCode     (rdCode),
    .strobe     (strobe),
    .synNonZero (synNonZero),
    .parityErr  (parityErr),
    .synInRange (synInRange),
    .rdDataOut  (rdDataOut)
  );

  secded_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .rdValid    (rdValid),
    .synNonZero (synNonZero),
    .parityErr  (parityErr),
    .synInRange (synInRange),
    .strobe     (strobe),
    .rdOutValid (rdOutValid),
    .errSingle  (errSingle),
    .errDouble  (errDouble)
  );

endmodule

// File: rtl/secded_unit_chk.sv
module secded_unit_chk #(
  parameter int DATA_W = 64,
  parameter int HC_W   = 7
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 rdValid,
  input logic [DATA_W+HC_W:0] rdCode,
  input logic                 rdOutValid,
  input logic [DATA_W-1:0]    rdDataOut,
  input logic                 errSingle,
  input logic                 errDouble
);
  // R3
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> rdOutValid);
  // R3
  idle_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |=> !rdOutValid);
  // R9
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({errSingle, errDouble}));
  // R9
  flags_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdOutValid |-> !errSingle && !errDouble);
  // R7
  even_parity_no_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && !(^rdCode) |=> !errSingle);
  // R5
  odd_parity_flagged_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && (^rdCode) |=> errSingle || errDouble);
  // R10
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |=> $stable(rdDataOut));
endmodule

bind secded_unit secded_unit_chk #(.DATA_W(DATA_W), .HC_W(HC_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .rdValid    (rdValid),
  .rdCode     (rdCode),
  .rdOutValid (rdOutValid),
  .rdDataOut  (rdDataOut),
  .errSingle  (errSingle),
  .errDouble  (errDouble)
);

// File: tb/sim_secded_unit.sv
module sim_secded_unit;
  logic        clk = 1'b0;
  logic        rstN;
  logic [63:0] wrData;
  logic [7:0]  wrCheck;
  logic        rdValid;
  logic [71:0] rdCode;
  logic        rdOutValid;
  logic [63:0] rdDataOut;
  logic        errSingle;
  logic        errDouble;

  int checks = 0;
  int fails  = 0;

  // pending expectation for the next sample
  logic        pV, pS, pDb;
  logic [63:0] pD;
  string       pTag;

  always #5 clk = ~clk;

  secded_unit u0 (
    .clk(clk), .rstN(rstN), .wrData(wrData), .wrCheck(wrCheck),
    .rdValid(rdValid), .rdCode(rdCode), .rdOutValid(rdOutValid),
    .rdDataOut(rdDataOut), .errSingle(errSingle), .errDouble(errDouble)
  );

  // R1 R2 reference encoder, written from the requirement text
  function automatic logic [7:0] refEncode(input logic [63:0] d);
    logic [6:0] h;
    int idx;
    h = '0;
    idx = 0;
    for (int p = 3; p < 72; p++) begin
      if ((p & (p - 1)) != 0) begin
        for (int j = 0; j < 7; j++) if (p[j]) h[j] = h[j] ^ d[idx];
        idx++;
      end
    end
    return {^{h, d}, h};
  endfunction

  task automatic checkEnc(input logic [63:0] d, input logic [7:0] exp, input string tag);
    wrData = d;
    #1;
    checks++;
    if (wrCheck !== exp) begin
      fails++;
      $display("FAIL %s encoder: got %h expected %h (data %h)", tag, wrCheck, exp, d);
    end
  endtask

  task automatic compareOut();
    checks++;
    if (rdOutValid !== pV || rdDataOut !== pD || errSingle !== pS || errDouble !== pDb) begin
      fails++;
      $display("FAIL %s: valid %0b/%0b data %h/%h single %0b/%0b double %0b/%0b",
               pTag, rdOutValid, pV, rdDataOut, pD, errSingle, pS, errDouble, pDb);
    end
  endtask

  task automatic cycle(input logic v, input logic [71:0] code, input logic [63:0] eD,
                       input logic eS, input logic eDb, input string tag);
    @(negedge clk);
    compareOut();
    rdValid = v;
    rdCode  = code;
    pV  = v;
    if (v) pD = eD;
    pS  = v && eS;
    pDb = v && eDb;
    pTag = tag;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] d;
    logic [71:0] cw;
    int a, b;
    rstN = 1'b0; rdValid = 1'b0; rdCode = '0; wrData = '0;
    pV = 0; pS = 0; pDb = 0; pD = '0; pTag = "R11 reset";
    repeat (3) @(negedge clk);
    compareOut();  // R11 state while in reset
    rstN = 1'b1;

    // R1 R2 fixed vectors
    checkEnc(64'h1, 8'h83, "R1 R2");
    checkEnc(64'h8000_0000_0000_0000, 8'hC7, "R1 R2");
    checkEnc(64'h0, 8'h00, "R1 R2");

    for (int it = 0; it < 600; it++) begin
      d = {$urandom(), $urandom()};
      checkEnc(d, refEncode(d), "R1 R2");
      cw = {refEncode(d), d};
      case (it % 6)
        0: cycle(1'b1, cw, d, 1'b0, 1'b0, "R3 R4 clean");
        1: begin
          a = $urandom_range(0, 63);
          cw[a] = ~cw[a];
          cycle(1'b1, cw, d, 1'b1, 1'b0, "R5 data flip");
        end
        2: begin
          a = $urandom_range(64, 71);
          cw[a] = ~cw[a];
          cycle(1'b1, cw, d, 1'b1, 1'b0, "R6 check flip");
        end
        3: begin
          a = $urandom_range(0, 71);
          b = (a + $urandom_range(1, 71)) % 72;
          cw[a] = ~cw[a];
          cw[b] = ~cw[b];
          cycle(1'b1, cw, cw[63:0], 1'b0, 1'b1, "R7 double");
        end
        4: begin
          cw[70:64] = ~cw[70:64];
          cycle(1'b1, cw, cw[63:0], 1'b0, 1'b1, "R8 bad syndrome");
        end
        default: cycle(1'b0, cw, 64'h0, 1'b0, 1'b0, "R3 R9 R10 idle");
      endcase
    end
    // back-to-back idles after traffic
    cycle(1'b0, '1, 64'h0, 1'b0, 1'b0, "R9 R10 idle");
    cycle(1'b0, '0, 64'h0, 1'b0, 1'b0, "R9 R10 idle");
    @(negedge clk);
    compareOut();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule